// File: doc/BRIEF.md
# Map-Reduce Element Loop Controller

This block is the sub-program-counter that sits between decode and issue for a vector-prefixed scalar instruction. When an instruction starts, the block captures the vector length, the ordering bit, the map-reduce bit and the scalar/vector marking of the source and destination. It then hands out one element operation at a time over a valid/ready handshake, giving the source and destination element numbers for each.

The walk goes upward from element 0. With reverse gear it goes downward from the last element. A scalar destination normally ends the loop after its first element operation. With map-reduce set, the loop instead keeps issuing every element into the same scalar destination, in strict order. Map-reduce with a vector destination changes nothing.

The count of element operations already handed out is held in a step register that is always visible. An interrupt freezes the loop on a handshake boundary, so the datapath's scalar destination already holds the partial result. The loop can be restarted later from the saved step. The datapath and the accumulation itself lie outside the block.

Top module: `elem_loop_ctl`

## Requirements
- R1: After reset, busy, issueValid and done are 0 and stepOut is 0.
- R2: With a vector destination and reverse gear clear, elements 0 to VL-1 are issued in increasing order. Each accepted handshake (issueValid and issueReady high at a clock edge) issues exactly one element and raises stepOut by one. dstIdx and srcIdx equal the element number.
- R3: With reverse gear set, element number VL-1-s is issued at step s, so the order runs from VL-1 down to 0. This holds for vector destinations too.
- R4: With a scalar destination and map-reduce clear, exactly one element operation is issued (element 0, or VL-1 under reverse gear) with dstIdx 0, and then the loop ends.
- R5: With a scalar destination and map-reduce set, all VL elements are issued in order. Each has dstIdx 0 and srcIdx following the element number.
- R6: Map-reduce with a vector destination issues the same sequence as the same loop without map-reduce.
- R7: When the source is marked scalar, srcIdx is 0 for every issued element.
- R8: While issueValid is high and issueReady is low (with no interrupt), issueValid stays high and srcIdx, dstIdx and stepOut hold.
- R9: An interrupt while busy stops the loop at the next edge without asserting done. An element accepted in that same cycle still counts, and stepOut keeps the number of elements issued.
- R10: Starting with resumeEn high loads resumeStep into the step register. Issue then continues with the next unissued element and the loop ends with the usual done.
- R11: A VL of 0 issues no element and asserts done in the first cycle after start.
- R12: A cfgVecLen above MAX_VL is treated as MAX_VL.
- R13: done is a single-cycle pulse that never coincides with issueValid, and the block is idle in the following cycle. start is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a loop; captures the configuration (ignored while busy) |
| cfgVecLen | input | VL_W | Vector length VL |
| cfgRevGear | input | 1 | Reverse-gear ordering |
| cfgMapReduce | input | 1 | Map-reduce mode |
| cfgDstScalar | input | 1 | Destination is scalar |
| cfgSrcScalar | input | 1 | Source is scalar |
| resumeEn | input | 1 | Start from resumeStep instead of 0 |
| resumeStep | input | VL_W | Saved step to resume from |
| irq | input | 1 | Interrupt: freeze the loop |
| issueValid | output | 1 | An element operation is offered |
| issueReady | input | 1 | Issue stage accepts the element |
| srcIdx | output | IDX_W | Source element number |
| dstIdx | output | IDX_W | Destination element number |
| stepOut | output | VL_W | Step register: elements issued so far |
| busy | output | 1 | Loop in progress |
| done | output | 1 | Loop finished normally (one cycle) |

## Verification
A corrupted step register shows up on the very next offered element as a wrong srcIdx/dstIdx. It also shows as a stepOut that fails to move by exactly one per accepted handshake. A wrong limit or a broken termination rule shows as an element too many or too few before done. The scoreboard catches this in the cycle of the extra issue, or when done arrives with expected items still queued. A lost freeze shows one cycle after the interrupt as busy still high or stepOut off by one.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
  typedef struct packed {
    logic load;     // capture configuration and initial step
    logic advance;  // one element accepted: step forward
  } loopStrobe_t;

  typedef enum logic {
    LOOP_IDLE = 1'b0,
    LOOP_RUN  = 1'b1
  } loopState_t;
endpackage

// File: rtl/elem_loop_dp.sv
module elem_loop_dp
  import elem_loop_pkg::*;
#(
  parameter int MAX_VL = 64
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  loopStrobe_t                       strobe,
  input  logic [$clog2(MAX_VL+1)-1:0]       cfgVecLen,
  input  logic                              cfgRevGear,
  input  logic                              cfgMapReduce,
  input  logic                              cfgDstScalar,
  input  logic                              cfgSrcScalar,
  input  logic                              resumeEn,
  input  logic [$clog2(MAX_VL+1)-1:0]       resumeStep,
  output logic                              more,
  output logic [$clog2(MAX_VL)-1:0]         srcIdx,
  output logic [$clog2(MAX_VL)-1:0]         dstIdx,
  output logic [$clog2(MAX_VL+1)-1:0]       stepOut
);
  localparam int VL_W  = $clog2(MAX_VL + 1);
  localparam int IDX_W = $clog2(MAX_VL);
  localparam logic [VL_W-1:0] ONE    = VL_W'(1);
  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  logic [VL_W-1:0] vlQ, stepQ;
  logic            rgQ, mrQ, dsQ, ssQ;
  logic [VL_W-1:0] vlClamped, limit, elemNum;

  assign vlClamped = (cfgVecLen > VL_CAP) ? VL_CAP : cfgVecLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlQ   <= '0;
      stepQ <= '0;
      rgQ   <= 1'b0;
      mrQ   <= 1'b0;
      dsQ   <= 1'b0;
      ssQ   <= 1'b0;
    end else if (strobe.load) begin
      vlQ   <= vlClamped;
      stepQ <= resumeEn ? resumeStep : '0;
      rgQ   <= cfgRevGear;
      mrQ   <= cfgMapReduce;
      dsQ   <= cfgDstScalar;
      ssQ   <= cfgSrcScalar;
    end else if (strobe.advance) begin
      stepQ <= stepQ + ONE;
    end
  end

  // Scalar destination without map-reduce: a single element at most.
  always_comb begin
    if (dsQ && !mrQ) limit = (vlQ != '0) ? ONE : '0;
    else             limit = vlQ;
  end

  assign more    = (stepQ < limit);
  assign elemNum = rgQ ? (vlQ - stepQ - ONE) : stepQ;
  assign srcIdx  = ssQ ? '0 : elemNum[IDX_W-1:0];
  assign dstIdx  = dsQ ? '0 : elemNum[IDX_W-1:0];
  assign stepOut = stepQ;
endmodule

// File: rtl/elem_loop_ctrl.sv
module elem_loop_ctrl
  import elem_loop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        irq,
  input  logic        issueReady,
  input  logic        more,
  output loopStrobe_t strobe,
  output logic        issueValid,
  output logic        busy,
  output logic        done
);
  loopState_t stateQ, stateD;
  logic       running;

  assign running    = (stateQ == LOOP_RUN);
  assign issueValid = running && more;
  assign done       = running && !more;
  assign busy       = running;

  always_comb begin
    strobe         = '0;
    strobe.load    = !running && start;
    strobe.advance = issueValid && issueReady;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      LOOP_IDLE: if (start) stateD = LOOP_RUN;
      LOOP_RUN:  if (irq || !more) stateD = LOOP_IDLE;
      default:   stateD = LOOP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= LOOP_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/elem_loop_ctl.sv
module elem_loop_ctl
  import elem_loop_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [VL_W-1:0]  cfgVecLen,
  input  logic             cfgRevGear,
  input  logic             cfgMapReduce,
  input  logic             cfgDstScalar,
  input  logic             cfgSrcScalar,
  input  logic             resumeEn,
  input  logic [VL_W-1:0]  resumeStep,
  input  logic             irq,
  output logic             issueValid,
  input  logic             issueReady,
  output logic [IDX_W-1:0] srcIdx,
  output logic [IDX_W-1:0] dstIdx,
  output logic [VL_W-1:0]  stepOut,
  output logic             busy,
  output logic             done
);
  loopStrobe_t strobe;
  logic        more;

  elem_loop_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .irq        (irq),
    .issueReady (issueReady),
    .more       (more),
    .strobe     (strobe),
    .issueValid (issueValid),
    .busy       (busy),
    .done       (done)
  );

  elem_loop_dp #(.MAX_VL(MAX_VL)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgVecLen    (cfgVecLen),
    .cfgRevGear   (cfgRevGear),
    .cfgMapReduce (cfgMapReduce),
    .cfgDstScalar (cfgDstScalar),
    .cfgSrcScalar (cfgSrcScalar),
    .resumeEn     (resumeEn),
    .resumeStep   (resumeStep),
    .more         (more),
    .srcIdx       (srcIdx),
    .dstIdx       (dstIdx),
    .stepOut      (stepOut)
  );
endmodule

// File: rtl/elem_loop_ctl_chk.sv
module elem_loop_ctl_chk #(
  parameter int VL_W  = 7,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             irq,
  input logic             issueValid,
  input logic             issueReady,
  input logic [IDX_W-1:0] srcIdx,
  input logic [IDX_W-1:0] dstIdx,
  input logic [VL_W-1:0]  stepOut,
  input logic             busy,
  input logic             done
);
  // R1: an idle block offers nothing and reports no completion
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!issueValid && !done));

  // R2: each accepted element moves the step by exactly one
  p_step_adv_r2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady) |=> (stepOut == $past(stepOut) + 1'b1));

  // R8: a stalled offer holds its indices
  p_hold_idx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueReady && !irq) |=>
      (issueValid && $stable(srcIdx) && $stable(dstIdx) && $stable(stepOut)));

  // R9: an interrupt freezes the loop at the next edge
  p_irq_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && irq) |=> !busy);

  // R13: completion never overlaps an offer, and is followed by idle
  p_done_excl_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !issueValid);

  p_done_ends_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));
endmodule

bind elem_loop_ctl elem_loop_ctl_chk #(.VL_W(VL_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .irq        (irq),
  .issueValid (issueValid),
  .issueReady (issueReady),
  .srcIdx     (srcIdx),
  .dstIdx     (dstIdx),
  .stepOut    (stepOut),
  .busy       (busy),
  .done       (done)
);

// File: tb/elem_loop_ctl_test.sv
module elem_loop_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL = 16;
  localparam int VL_W  = $clog2(MAX_VL + 1);
  localparam int IDX_W = $clog2(MAX_VL);

  logic             clk, rstN, start, irq, issueReady;
  logic [VL_W-1:0]  cfgVecLen, resumeStep, stepOut;
  logic             cfgRevGear, cfgMapReduce, cfgDstScalar, cfgSrcScalar, resumeEn;
  logic             issueValid, busy, done;
  logic [IDX_W-1:0] srcIdx, dstIdx;

  elem_loop_ctl #(.MAX_VL(MAX_VL)) uut (
    .clk(clk), .rstN(rstN), .start(start), .cfgVecLen(cfgVecLen),
    .cfgRevGear(cfgRevGear), .cfgMapReduce(cfgMapReduce),
    .cfgDstScalar(cfgDstScalar), .cfgSrcScalar(cfgSrcScalar),
    .resumeEn(resumeEn), .resumeStep(resumeStep), .irq(irq),
    .issueValid(issueValid), .issueReady(issueReady),
    .srcIdx(srcIdx), .dstIdx(dstIdx), .stepOut(stepOut),
    .busy(busy), .done(done)
  );

  typedef struct {
    int    src;
    int    dst;
    string tag;
  } item_t;

  item_t      expQ[$];
  int         checks = 0;
  int         fails  = 0;
  int         readyMode = 0;
  logic [7:0] lfsr = 8'hA5;
  bit         finished = 0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Ready pattern driver
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (readyMode)
      0:       issueReady = 1'b1;
      1:       issueReady = lfsr[0];
      default: issueReady = 1'b0;
    endcase
  end

  // Monitor: compare every accepted element against the scoreboard
  always @(negedge clk) begin
    if (rstN && issueValid && issueReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R4", "unexpected extra element, dstIdx", int'(dstIdx), -1);
      end else begin
        item_t e;
        e = expQ.pop_front();
        chk(int'(srcIdx) == e.src, e.tag, "srcIdx", int'(srcIdx), e.src);
        chk(int'(dstIdx) == e.dst, e.tag, "dstIdx", int'(dstIdx), e.dst);
      end
    end
  end

  // Driver: compute expected items from the requirements
  task automatic pushExp(int vl, bit rg, bit mr, bit ds, bit ss, int firstStep,
                         int stopStep, string tag, output int limit);
    int effVl;
    effVl = (vl > MAX_VL) ? MAX_VL : vl;
    limit = (ds && !mr) ? ((effVl > 0) ? 1 : 0) : effVl;
    for (int s = firstStep; s < limit && (stopStep < 0 || s < stopStep); s++) begin
      item_t e;
      int    el;
      el    = rg ? (effVl - 1 - s) : s;
      e.src = ss ? 0 : el;
      e.dst = ds ? 0 : el;
      e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic kick(int vl, bit rg, bit mr, bit ds, bit ss, bit res, int rstep);
    @(posedge clk); #2;
    cfgVecLen    = VL_W'(vl);
    cfgRevGear   = rg;
    cfgMapReduce = mr;
    cfgDstScalar = ds;
    cfgSrcScalar = ss;
    resumeEn     = res;
    resumeStep   = VL_W'(rstep);
    start        = 1'b1;
    @(posedge clk); #2;
    start        = 1'b0;
  endtask

  task automatic waitDone(int limit, string tag);
    int guard;
    guard = 0;
    @(negedge clk);
    while (!done && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, tag, "done reached", int'(done), 1);
    chk(expQ.size() == 0, tag, "elements left unissued", expQ.size(), 0);
    chk(int'(stepOut) == limit, tag, "stepOut at done", int'(stepOut), limit);
    chk(issueValid == 1'b0, "R13", "issueValid with done", int'(issueValid), 0);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R13", "idle after done", int'(busy) + int'(done), 0);
  endtask

  task automatic runLoop(int vl, bit rg, bit mr, bit ds, bit ss, string tag);
    int limit;
    pushExp(vl, rg, mr, ds, ss, 0, -1, tag, limit);
    kick(vl, rg, mr, ds, ss, 1'b0, 0);
    waitDone(limit, tag);
  endtask

  // Interrupt accepted together with the irqAt-th element
  task automatic runIrq(int vl, bit rg, bit mr, bit ds, int irqAt);
    int limit;
    int guard;
    pushExp(vl, rg, mr, ds, 1'b0, 0, irqAt, "R9", limit);
    readyMode = 0;
    kick(vl, rg, mr, ds, 1'b0, 1'b0, 0);
    guard = 0;
    while (int'(stepOut) != irqAt - 1 && guard < 200) begin
      @(posedge clk); #2;
      guard++;
    end
    irq = 1'b1;
    @(posedge clk); #2;
    irq = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after irq", int'(busy), 0);
    chk(done == 1'b0, "R9", "done after irq", int'(done), 0);
    chk(int'(stepOut) == irqAt, "R9", "saved stepOut", int'(stepOut), irqAt);
    chk(expQ.size() == 0, "R9", "elements before irq", expQ.size(), 0);
    repeat (2) @(negedge clk);
    chk(int'(stepOut) == irqAt, "R9", "stepOut frozen", int'(stepOut), irqAt);
    // R10: resume from the saved step
    pushExp(vl, rg, mr, ds, 1'b0, irqAt, -1, "R10", limit);
    kick(vl, rg, mr, ds, 1'b0, 1'b1, irqAt);
    waitDone(limit, "R10");
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; irq = 1'b0; issueReady = 1'b1;
    cfgVecLen = '0; cfgRevGear = 1'b0; cfgMapReduce = 1'b0;
    cfgDstScalar = 1'b0; cfgSrcScalar = 1'b0; resumeEn = 1'b0; resumeStep = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(issueValid == 1'b0, "R1", "issueValid in reset", int'(issueValid), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    chk(stepOut == '0, "R1", "stepOut in reset", int'(stepOut), 0);
    @(posedge clk); #2;
    rstN = 1'b1;

    readyMode = 0;
    runLoop(5, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    readyMode = 1;
    runLoop(7, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    readyMode = 0;
    runLoop(6, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    runLoop(5, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    runLoop(5, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
    runLoop(6, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    readyMode = 1;
    runLoop(4, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
    readyMode = 0;
    runLoop(5, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    runLoop(5, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    runLoop(4, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    runLoop(0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
    runLoop(MAX_VL + 3, 1'b0, 1'b0, 1'b0, 1'b0, "R12");

    // R8: stall with ready held low
    begin
      int limit;
      pushExp(3, 1'b1, 1'b0, 1'b0, 1'b0, 0, -1, "R8", limit);
      readyMode = 2;
      kick(3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
      repeat (4) @(negedge clk);
      chk(issueValid == 1'b1, "R8", "issueValid held", int'(issueValid), 1);
      chk(int'(dstIdx) == 2, "R8", "dstIdx held", int'(dstIdx), 2);
      chk(stepOut == '0, "R8", "stepOut held", int'(stepOut), 0);
      // R13: start while busy is ignored
      @(posedge clk); #2;
      cfgVecLen = VL_W'(9); start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      @(negedge clk);
      chk(int'(dstIdx) == 2 && stepOut == '0, "R13", "start ignored, dstIdx", int'(dstIdx), 2);
      readyMode = 0;
      waitDone(limit, "R8");
    end

    runIrq(8, 1'b1, 1'b1, 1'b1, 3);
    runIrq(6, 1'b0, 1'b0, 1'b0, 1);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule